// File: doc/BRIEF.md
# Embedded Timing Reference Video Stream Decoder

This block sits on an 8-bit multiplexed YCbCr 4:2:2 byte stream, clocked at the sample rate, and takes all of its line and field timing from the stream itself. There are no separate sync wires. It looks for the three-byte preamble `FF 00 00` and reads the status byte that follows. From that byte it takes the field, vertical-blanking and start/end-of-active flags, and it checks them against the protection bits.

A start-of-active code with vertical blanking clear opens an active line. The block marks the next `ACTIVE_SAMPLES` accepted bytes as active, collects them four at a time into a Cb/Y0/Cr/Y1 pixel pair, and presents each pair with a one-cycle strobe. When the matching end-of-active code arrives, the block checks that the line held exactly the configured number of samples. It raises a one-cycle error pulse for a malformed line or for a corrupted status byte. Bytes presented with `din_en` low are ignored, so the source may stall the stream at any point.

Top module: `vid_tref_decoder`

## Requirements
- R1: A timing code is detected when three accepted bytes `0xFF, 0x00, 0x00` are followed by a fourth accepted byte, which is the status byte. A stray `0xFF` at any point in the preamble restarts the match at the first-byte stage, so `FF FF 00 00 st` is detected.
- R2: The status byte is decoded as bit 7 = 1 (fixed), bit 6 = F (field), bit 5 = V (vertical blanking) and bit 4 = H (0 = start of active video, 1 = end of active video). After a valid code, `field_o` and `vblank_o` show F and V from the cycle after the status byte.
- R3: The protection bits [3:0] must equal {V^H, F^H, F^V, F^V^H} and bit 7 must be 1. Otherwise `err` pulses high for exactly one cycle after the status byte, `field_o` and `vblank_o` keep their previous values, and no line opens.
- R4: After a valid start code with V=0, `active` rises in the cycle after the status byte. It stays high for exactly `ACTIVE_SAMPLES` accepted bytes and falls in the cycle after the last of them. A start code with V=1 leaves `active` low.
- R5: Active bytes are taken in the order Cb, Y0, Cr, Y1. In the cycle after each Y1, `pair_valid` pulses and `cb_out`, `y0_out`, `cr_out` and `y1_out` hold the four bytes of that pair.
- R6: `line_start` pulses for one cycle after a valid start code with V=0. `line_end` pulses for one cycle after a valid end code that closes an open line. The two never pulse together.
- R7: When a valid end code closes an open line, `err` pulses if the number of accepted bytes since the start code, excluding the end code's own four bytes, differs from `ACTIVE_SAMPLES`. This covers both short and long lines.
- R8: A byte with `din_en` low neither advances the preamble match nor counts as a sample, and it changes no output.
- R9: While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Multiplexed YCbCr byte stream |
| din_en | input | 1 | Byte on `din` is valid this cycle |
| cb_out | output | 8 | Cb of the last completed pixel pair |
| y0_out | output | 8 | First luma of the last pair |
| cr_out | output | 8 | Cr of the last pair |
| y1_out | output | 8 | Second luma of the last pair |
| pair_valid | output | 1 | One-cycle strobe: a new pair is on the pair outputs |
| active | output | 1 | The next accepted byte is an active sample |
| field_o | output | 1 | Field flag from the last valid code |
| vblank_o | output | 1 | Vertical-blanking flag from the last valid code |
| line_start | output | 1 | One-cycle pulse after a start-of-active code |
| line_end | output | 1 | One-cycle pulse after the end code closing a line |
| err | output | 1 | One-cycle pulse: bad protection bits or wrong line length |

## Verification
The bench builds the block with `ACTIVE_SAMPLES` = 8 instead of the full-line value of 1440. Each active line is then two pixel pairs long, and the exact fall of `active` after the final sample can be checked row by row. The short value also makes lines one pair short or two bytes long cheap to build, so the length check on the end code is covered from both sides. Stalls inside the preamble and inside active video, overlapping `0xFF` bytes, corrupted protection bits, vertical-blanking start codes and a reset during an open line all fit in a few hundred cycles.

// File: rtl/vsd_pkg.sv
// Package vsd_pkg
// Shared types and helpers for the timing-reference stream decoder.
// Assumes the status byte keeps its flags in the top nibble and its
// protection bits in the low nibble.
package vsd_pkg;

    // Progress of the three-byte preamble match.
    typedef enum logic [1:0] {
        PM_IDLE   = 2'd0,
        PM_FF     = 2'd1,
        PM_FF00   = 2'd2,
        PM_FF0000 = 2'd3
    } pm_state_t;

    // Flags carried by a status byte.
    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tref_flags_t;

    // Expected protection nibble for a given flag set.
    function automatic logic [3:0] tref_protect(input tref_flags_t fl);
        return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction

endpackage

// File: rtl/vsd_preamble.sv
// Module vsd_preamble
// Matches the FF 00 00 preamble on accepted bytes and decodes the status
// byte that follows it, combinationally, in the cycle that byte arrives.
// Assumes DW >= 8; the flag and protection positions are fixed.
module vsd_preamble
    import vsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          din_en,
    output logic          code_stb,
    output logic          code_ok,
    output tref_flags_t   code_flags
);

    localparam logic [DW-1:0] BYTE_ONES  = {DW{1'b1}};
    localparam logic [DW-1:0] BYTE_ZEROS = {DW{1'b0}};

    pm_state_t state_q;
    pm_state_t state_d;

    // Next-state logic for the preamble search, restarting on stray 0xFF.
    always_comb begin
        state_d = state_q;
        if (din_en) begin
            unique case (state_q)
                PM_IDLE:   state_d = (din == BYTE_ONES) ? PM_FF : PM_IDLE;
                PM_FF:     state_d = (din == BYTE_ZEROS) ? PM_FF00 :
                                     (din == BYTE_ONES)  ? PM_FF   : PM_IDLE;
                PM_FF00:   state_d = (din == BYTE_ZEROS) ? PM_FF0000 :
                                     (din == BYTE_ONES)  ? PM_FF     : PM_IDLE;
                PM_FF0000: state_d = PM_IDLE;
                default:   state_d = PM_IDLE;
            endcase
        end
    end

    // Preamble state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_IDLE;
        else        state_q <= state_d;
    end

    // Status byte decode and protection check.
    always_comb begin
        code_stb         = din_en && (state_q == PM_FF0000);
        code_flags.f     = din[DW-2];
        code_flags.v     = din[DW-3];
        code_flags.h     = din[DW-4];
        code_ok          = din[DW-1] && (din[3:0] == tref_protect(code_flags));
    end

    // R1: a status byte is only ever taken straight after the third preamble byte.
    assert_status_after_preamble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb |-> ($past(din_en) ? $past(din) == BYTE_ZEROS : 1'b1));

endmodule

// File: rtl/vsd_line_tracker.sv
// Module vsd_line_tracker
// Holds the field/blanking flags, opens and closes active lines on
// valid timing codes, gates the active-sample window and checks the
// byte count at the closing code.
// Assumes codes arrive at least four accepted bytes apart.
module vsd_line_tracker
    import vsd_pkg::*;
#(
    parameter int ACTIVE_SAMPLES = 1440
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        din_en,
    input  logic        code_stb,
    input  logic        code_ok,
    input  tref_flags_t code_flags,
    output logic        in_line,
    output logic        take,
    output logic        sav_now,
    output logic        len_bad,
    output logic        line_start,
    output logic        line_end,
    output logic        field_q,
    output logic        vblank_q
);

    localparam int            CW      = $clog2(ACTIVE_SAMPLES + 5);
    localparam logic [CW-1:0] CNT_N   = CW'(ACTIVE_SAMPLES);
    localparam logic [CW-1:0] CNT_LST = CW'(ACTIVE_SAMPLES - 1);
    localparam logic [CW-1:0] CNT_EAV = CW'(ACTIVE_SAMPLES + 3);
    localparam logic [CW-1:0] CNT_MAX = CW'(ACTIVE_SAMPLES + 4);

    logic          line_open;
    logic [CW-1:0] cnt;
    logic          eav_now;

    // Classify the code in flight and gate sample acceptance.
    always_comb begin
        sav_now = code_stb && code_ok && !code_flags.h && !code_flags.v;
        eav_now = code_stb && code_ok && code_flags.h;
        take    = din_en && in_line && !code_stb;
        len_bad = eav_now && line_open && (cnt != CNT_EAV);
    end

    // Line window, byte counter, flags and line pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_open  <= 1'b0;
            in_line    <= 1'b0;
            cnt        <= '0;
            line_start <= 1'b0;
            line_end   <= 1'b0;
            field_q    <= 1'b0;
            vblank_q   <= 1'b0;
        end else begin
            line_start <= sav_now;
            line_end   <= eav_now && line_open;
            if (code_stb && code_ok) begin
                field_q  <= code_flags.f;
                vblank_q <= code_flags.v;
            end
            if (sav_now) begin
                line_open <= 1'b1;
                in_line   <= 1'b1;
                cnt       <= '0;
            end else if (eav_now) begin
                line_open <= 1'b0;
                in_line   <= 1'b0;
            end else if (din_en && line_open) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (in_line && cnt == CNT_LST) in_line <= 1'b0;
            end
        end
    end

    // R4: the active window never runs past the sample budget.
    assert_active_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_line |-> cnt < CNT_N);

    // R4: the active window only opens together with a line start.
    assert_active_opens_on_sav_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_line) |-> line_start);

    // R3: flags change only after a valid code.
    assert_field_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_q) |-> $past(code_stb && code_ok));
    assert_vblank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank_q) |-> $past(code_stb && code_ok));

endmodule

// File: rtl/vsd_pair_builder.sv
// Module vsd_pair_builder
// Collects accepted active bytes in Cb, Y0, Cr, Y1 order and presents
// each completed pair with a one-cycle strobe.
// Assumes restart and take are never high together.
module vsd_pair_builder #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          take,
    input  logic          restart,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] y0_out,
    output logic [DW-1:0] cr_out,
    output logic [DW-1:0] y1_out,
    output logic          pair_valid
);

    logic [1:0]    phase;
    logic [DW-1:0] cb_h;
    logic [DW-1:0] y0_h;
    logic [DW-1:0] cr_h;

    // Byte phase tracking, holding registers and pair output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= 2'd0;
            cb_h       <= '0;
            y0_h       <= '0;
            cr_h       <= '0;
            cb_out     <= '0;
            y0_out     <= '0;
            cr_out     <= '0;
            y1_out     <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (restart) begin
                phase <= 2'd0;
            end else if (take) begin
                phase <= phase + 2'd1;
                unique case (phase)
                    2'd0: cb_h <= din;
                    2'd1: y0_h <= din;
                    2'd2: cr_h <= din;
                    2'd3: begin
                        cb_out     <= cb_h;
                        y0_out     <= y0_h;
                        cr_out     <= cr_h;
                        y1_out     <= din;
                        pair_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: pairs are at least four bytes apart, so strobes never repeat back to back.
    assert_pair_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R5: pair outputs only move with a strobe.
    assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> $stable(y1_out));

endmodule

// File: rtl/vid_tref_decoder.sv
// Module vid_tref_decoder
// Top level: decodes embedded timing codes from a multiplexed YCbCr
// 4:2:2 byte stream, marks active video, splits it into pixel pairs
// and flags malformed codes and lines.
// Assumes one byte per enabled clock; ACTIVE_SAMPLES is a multiple of 4.
module vid_tref_decoder
    import vsd_pkg::*;
#(
    parameter int DW             = 8,
    parameter int ACTIVE_SAMPLES = 1440
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          din_en,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] y0_out,
    output logic [DW-1:0] cr_out,
    output logic [DW-1:0] y1_out,
    output logic          pair_valid,
    output logic          active,
    output logic          field_o,
    output logic          vblank_o,
    output logic          line_start,
    output logic          line_end,
    output logic          err
);

    logic        code_stb;
    logic        code_ok;
    tref_flags_t code_flags;
    logic        take;
    logic        sav_now;
    logic        len_bad;

    vsd_preamble #(.DW(DW)) u_preamble (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .din_en     (din_en),
        .code_stb   (code_stb),
        .code_ok    (code_ok),
        .code_flags (code_flags)
    );

    vsd_line_tracker #(.ACTIVE_SAMPLES(ACTIVE_SAMPLES)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .din_en     (din_en),
        .code_stb   (code_stb),
        .code_ok    (code_ok),
        .code_flags (code_flags),
        .in_line    (active),
        .take       (take),
        .sav_now    (sav_now),
        .len_bad    (len_bad),
        .line_start (line_start),
        .line_end   (line_end),
        .field_q    (field_o),
        .vblank_q   (vblank_o)
    );

    vsd_pair_builder #(.DW(DW)) u_pairs (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .take       (take),
        .restart    (sav_now),
        .cb_out     (cb_out),
        .y0_out     (y0_out),
        .cr_out     (cr_out),
        .y1_out     (y1_out),
        .pair_valid (pair_valid)
    );

    // Error pulse: corrupted status byte or wrong line length.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (code_stb && !code_ok) || len_bad;
    end

    // R3: the error flag is a single-cycle pulse.
    assert_err_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R6: line start and line end are never reported together.
    assert_start_end_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_start && line_end));

    // R6: a line end can only follow a closed active window.
    assert_end_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> !active);

endmodule

// File: tb/vid_tref_decoder_bench.sv
module vid_tref_decoder_bench;

    localparam int N  = 8;
    localparam int VW = 46;   // en, din[8], act, pv, ls, le, err, pair[32]

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       din_en = 1'b0;
    logic [7:0] cb_out, y0_out, cr_out, y1_out;
    logic       pair_valid, active, field_o, vblank_o, line_start, line_end, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vid_tref_decoder #(.DW(8), .ACTIVE_SAMPLES(N)) u_vid_tref_decoder (
        .clk(clk), .rst_n(rst_n), .din(din), .din_en(din_en),
        .cb_out(cb_out), .y0_out(y0_out), .cr_out(cr_out), .y1_out(y1_out),
        .pair_valid(pair_valid), .active(active), .field_o(field_o),
        .vblank_o(vblank_o), .line_start(line_start), .line_end(line_end),
        .err(err)
    );

    // Status byte built from the requirement formula (R2, R3).
    function automatic logic [7:0] st(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // One line of N=8 samples with a stall, walked row by row.
    localparam logic [VW-1:0] VEC [20] = '{
        {1'b1, 8'h80, 5'b00000, 32'h0},
        {1'b1, 8'h10, 5'b00000, 32'h0},
        {1'b1, 8'hFF, 5'b00000, 32'h0},
        {1'b1, 8'h00, 5'b00000, 32'h0},
        {1'b1, 8'h00, 5'b00000, 32'h0},
        {1'b1, 8'h80, 5'b10100, 32'h0},
        {1'b1, 8'h11, 5'b10000, 32'h0},
        {1'b1, 8'h22, 5'b10000, 32'h0},
        {1'b1, 8'h33, 5'b10000, 32'h0},
        {1'b1, 8'h44, 5'b11000, 32'h11223344},
        {1'b0, 8'hEE, 5'b10000, 32'h0},
        {1'b1, 8'h55, 5'b10000, 32'h0},
        {1'b1, 8'h66, 5'b10000, 32'h0},
        {1'b1, 8'h77, 5'b10000, 32'h0},
        {1'b1, 8'h88, 5'b01000, 32'h55667788},
        {1'b1, 8'hFF, 5'b00000, 32'h0},
        {1'b1, 8'h00, 5'b00000, 32'h0},
        {1'b1, 8'h00, 5'b00000, 32'h0},
        {1'b1, 8'h9D, 5'b00010, 32'h0},
        {1'b1, 8'h80, 5'b00000, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one byte at a falling edge; return at the next falling edge.
    task automatic put(input logic [7:0] b, input logic e);
        din    = b;
        din_en = e;
        @(negedge clk);
        din_en = 1'b0;
    endtask

    task automatic code(input logic f, input logic v, input logic h);
        put(8'hFF, 1'b1);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        put(st(f, v, h), 1'b1);
    endtask

    function automatic logic [4:0] flags();
        return {active, pair_valid, line_start, line_end, err};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset outputs", {cb_out, y0_out, cr_out, y1_out},  32'h0);
        chk("R9 reset flags", {27'h0, flags()}, 32'h0);
        chk("R9 reset fv", {30'h0, field_o, vblank_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4 R5 R6 R8: table-driven nominal line
        foreach (VEC[i]) begin
            put(VEC[i][44:37], VEC[i][45]);
            chk($sformatf("R4/R5/R6/R8 row %0d", i), {27'h0, flags()}, {27'h0, VEC[i][36:32]});
            if (VEC[i][35])
                chk($sformatf("R5 pair row %0d", i), {cb_out, y0_out, cr_out, y1_out}, VEC[i][31:0]);
        end

        // R1: stray 0xFF restarts preamble
        put(8'hFF, 1'b1);
        put(8'hFF, 1'b1);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        put(st(0, 0, 0), 1'b1);
        chk("R1 overlap FF detected", {31'h0, line_start}, 32'h1);
        for (int k = 0; k < N; k++) put(8'h20 + 8'(k), 1'b1);
        code(0, 0, 1);
        chk("R7 exact length no err", {30'h0, line_end, err}, 32'h2);

        // R8: stall inside preamble does not break it
        put(8'hFF, 1'b1);
        put(8'h00, 1'b0);
        put(8'h00, 1'b1);
        put(8'hFF, 1'b0);
        put(8'h00, 1'b1);
        put(st(0, 0, 0), 1'b1);
        chk("R8 stalled preamble", {31'h0, line_start}, 32'h1);
        put(8'h00, 1'b0);
        chk("R8 disabled byte not taken", {31'h0, active}, 32'h1);
        for (int k = 0; k < N; k++) put(8'h40, 1'b1);
        code(0, 0, 1);

        // R3: bad protection bits
        put(8'hFF, 1'b1);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        put(8'hC0, 1'b1);
        chk("R3 bad parity err", {29'h0, err, line_start, field_o}, 32'h4);
        put(8'h10, 1'b1);
        chk("R3 err one cycle", {31'h0, err}, 32'h0);
        // R3: bit 7 clear
        put(8'hFF, 1'b1);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        chk("R3 bit7 clear err", {30'h0, err, active}, 32'h2);

        // R2 R4: vertical blanking start code
        code(0, 1, 0);
        chk("R2 vblank flag", {30'h0, field_o, vblank_o}, 32'h1);
        chk("R4 V=1 no active", {30'h0, active, line_start}, 32'h0);
        code(1, 0, 0);
        chk("R2 field flag", {29'h0, field_o, vblank_o, active}, 32'h5);
        for (int k = 0; k < N; k++) put(8'h50, 1'b1);
        code(1, 0, 1);
        chk("R2 field end no err", {30'h0, line_end, err}, 32'h2);

        // R7: short line
        code(0, 0, 0);
        for (int k = 0; k < N - 4; k++) put(8'h60, 1'b1);
        code(0, 0, 1);
        chk("R7 short line err", {29'h0, line_end, err, active}, 32'h6);

        // R7: long line
        code(0, 0, 0);
        for (int k = 0; k < N + 2; k++) put(8'h70, 1'b1);
        code(0, 0, 1);
        chk("R7 long line err", {30'h0, line_end, err}, 32'h3);

        // R9: reset during an open line
        code(1, 0, 0);
        put(8'h12, 1'b1);
        put(8'h34, 1'b1);
        put(8'h56, 1'b1);
        put(8'h78, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-line reset flags", {27'h0, flags()}, 32'h0);
        chk("R9 mid-line reset pair", {cb_out, y0_out, cr_out, y1_out}, 32'h0);
        chk("R9 mid-line reset fv", {30'h0, field_o, vblank_o}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule